// File: doc/BRIEF.md
# Dual-Buffer Word Copy DMA

This block copies runs of 32-bit words between two local memories: a packet endpoint buffer with a 10-bit word address and a framed line-data buffer with a 14-bit word address. Copies can run in either direction. Software first writes a start word offset for each buffer. It then writes one control word that gives the direction and the length, and that write launches the copy. While the copy runs, software can poll a status word. The status word shows whether the engine is busy, which direction it is copying, and how many words are left.

The engine has two pipeline stages. In the first cycle it puts a word address on the source memory. In the next cycle it writes the returned word to the destination memory. Both memories are simple synchronous RAMs: read data appears one cycle after the address is presented. The register side is a 32-bit single-beat slave port. It acknowledges every access one cycle after the access is presented.

Top module: `word_copy_dma`

## Requirements
- R1: An access presented on the register port (`reg_valid` high while `reg_ack` is low) is acknowledged by `reg_ack` high on the next cycle only. `reg_ack` then drops for at least one cycle.
- R2: A read of byte address 0x0 returns the status word: bit 15 is busy, bit 14 is the direction of the most recent accepted transfer, bits 12:0 are the remaining count, and all other bits are zero.
- R3: A write to byte address 0x0 while idle starts a transfer. Bit 14 is the direction, and bits 11:0 hold a length field L. The transfer moves exactly L+2 words. All other bits of the write are ignored.
- R4: The remaining count is loaded with L+1 at the start and drops by one for each word written. It reads 0x1FFF (all ones) once the transfer is done. Busy clears on the same clock edge as the last write. The largest length field, 4095, moves 4097 words.
- R5: The first source address appears in the cycle after the start write is accepted. Each destination write comes one cycle after its source read and carries that read's data. Both addresses step by one word per word moved. They wrap at the buffer size: 1024 words for the endpoint buffer, 16384 words for the line buffer.
- R6: Direction 0 copies the line buffer into the endpoint buffer. Direction 1 copies the endpoint buffer into the line buffer. Only the destination memory ever sees a write enable.
- R7: A start write accepted while busy is ignored. The running transfer, its direction and its count are unaffected.
- R8: Byte address 0x8 sets the line-buffer start offset from bits 13:0. Byte address 0xC sets the endpoint-buffer start offset from bits 9:0. An offset written during a transfer takes effect only at the next start.
- R9: Reads of any address other than 0x0, including 0x8 and 0xC, return zero.
- R10: After reset the engine is idle, the remaining count is all ones, both offsets are zero, and no memory write occurs until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access presented |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with `reg_ack` |
| reg_ack | output | 1 | Access acknowledge |
| ln_addr | output | 14 | Line buffer word address |
| ln_wdata | output | 32 | Line buffer write data |
| ln_we | output | 1 | Line buffer write enable |
| ln_rdata | input | 32 | Line buffer read data (one cycle latency) |
| ep_addr | output | 10 | Endpoint buffer word address |
| ep_wdata | output | 32 | Endpoint buffer write data |
| ep_we | output | 1 | Endpoint buffer write enable |
| ep_rdata | input | 32 | Endpoint buffer read data (one cycle latency) |

## Verification
The hardest situations to reach from the ports are the ones inside a running transfer: a second start request and offset rewrites arriving while the copy is still going. The bench launches a long copy and, before it ends, rewrites both offsets and issues a start with the opposite direction. Status polls must then still show the first transfer's direction and count. The follow-up transfer must land at the new offsets. Address wrap is reached by placing start offsets a few words below the top of each buffer. The largest length field is also used, so that the endpoint buffer wraps several times.

// File: rtl/dma_cp_pkg.sv
// Shared constants for the word copy DMA: status bit positions and counter widths.
package dma_cp_pkg;
    localparam int LEN_W    = 12;        // programmed length field width
    localparam int CNT_W    = LEN_W + 1; // remaining count, all ones means done
    localparam int BIT_BUSY = 15;
    localparam int BIT_DIR  = 14;

    typedef enum logic {
        DIR_LN2EP = 1'b0,
        DIR_EP2LN = 1'b1
    } dir_e;
endpackage

// File: rtl/dma_cp_regs.sv
// Register slave for the copy DMA. Decodes the control word, holds the two start
// offsets and returns status. Assumes the master holds reg_valid until reg_ack.
module dma_cp_regs
    import dma_cp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 32,
    parameter int LN_AW  = 14,
    parameter int EP_AW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_ack,
    input  logic              st_busy,
    input  dir_e              st_dir,
    input  logic [CNT_W-1:0]  st_cnt,
    output logic              start_req,
    output dir_e              req_dir,
    output logic [LEN_W-1:0]  req_len,
    output logic [LN_AW-1:0]  ln_ofs,
    output logic [EP_AW-1:0]  ep_ofs
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] A_LN_OFS = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] A_EP_OFS = ADDR_W'(4'hC);

    logic          acc;
    logic [DW-1:0] status;
    logic          unused_wdata;

    assign acc          = reg_valid && !reg_ack;
    assign start_req    = acc && reg_we && (reg_addr == A_CTRL);
    assign req_dir      = dir_e'(reg_wdata[BIT_DIR]);
    assign req_len      = reg_wdata[LEN_W-1:0];
    assign unused_wdata = ^reg_wdata[DW-1:BIT_DIR+1];

    // Build the status word from the engine state.
    always_comb begin
        status              = '0;
        status[BIT_BUSY]    = st_busy;
        status[BIT_DIR]     = st_dir;
        status[CNT_W-1:0]   = st_cnt;
    end

    // Acknowledge each presented access exactly one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_ack <= 1'b0;
        else        reg_ack <= acc;
    end

    // Read data: status at the control address, zero anywhere else.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    reg_rdata <= '0;
        else if (acc && !reg_we && reg_addr == A_CTRL) reg_rdata <= status;
        else                                           reg_rdata <= '0;
    end

    // Offset registers, loaded by writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_ofs <= '0;
            ep_ofs <= '0;
        end else if (acc && reg_we) begin
            if (reg_addr == A_LN_OFS) ln_ofs <= reg_wdata[LN_AW-1:0];
            if (reg_addr == A_EP_OFS) ep_ofs <= reg_wdata[EP_AW-1:0];
        end
    end

    p_ack_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_ack |=> reg_ack);
    p_ack_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);
    p_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack && $past(reg_addr) != A_CTRL |-> reg_rdata == '0);
endmodule

// File: rtl/dma_cp_ctrl.sv
// Transfer sequencer: accepts a start while idle, issues L+2 source reads and
// follows each with a destination write one cycle later, counting down to all ones.
module dma_cp_ctrl
    import dma_cp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  dir_e             req_dir,
    input  logic [LEN_W-1:0] req_len,
    output logic             start_go,
    output logic             rd_act,
    output logic             wr_vld,
    output logic             busy,
    output dir_e             dir,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] rd_left;
    logic [CNT_W-1:0] load_val;

    assign start_go = start_req && !busy;
    assign load_val = {1'b0, req_len} + CNT_W'(1);

    // Sequence reads, writes, the remaining count and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            dir     <= DIR_LN2EP;
            cnt     <= '1;
            rd_act  <= 1'b0;
            rd_left <= '0;
            wr_vld  <= 1'b0;
        end else begin
            wr_vld <= rd_act;
            if (start_go) begin
                busy    <= 1'b1;
                dir     <= req_dir;
                cnt     <= load_val;
                rd_act  <= 1'b1;
                rd_left <= load_val;
            end else begin
                if (rd_act) begin
                    if (rd_left == '0) rd_act  <= 1'b0;
                    else               rd_left <= rd_left - 1'b1;
                end
                if (wr_vld) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == '0) busy <= 1'b0;
                end
            end
        end
    end

    p_done_allones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> &cnt);
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_vld && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_req |=> $stable(dir));
    p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> busy);
endmodule

// File: rtl/dma_cp_ptr.sv
// Word address pointer for one buffer: loaded from the start offset, stepped by
// one per word moved, wrapping naturally at the buffer's address width.
module dma_cp_ptr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ofs,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    // Load at start, otherwise advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= ofs;
        else if (step) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/word_copy_dma.sv
// Dual-buffer word copy DMA top. Connects the register slave, the sequencer and
// one pointer per buffer; the source pointer steps on reads, the destination on writes.
module word_copy_dma
    import dma_cp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DW     = 32,
    parameter int LN_AW  = 14,
    parameter int EP_AW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_ack,
    output logic [LN_AW-1:0]  ln_addr,
    output logic [DW-1:0]     ln_wdata,
    output logic              ln_we,
    input  logic [DW-1:0]     ln_rdata,
    output logic [EP_AW-1:0]  ep_addr,
    output logic [DW-1:0]     ep_wdata,
    output logic              ep_we,
    input  logic [DW-1:0]     ep_rdata
);
    logic             start_req, start_go, rd_act, wr_vld, busy;
    dir_e             req_dir, dir;
    logic [LEN_W-1:0] req_len;
    logic [CNT_W-1:0] cnt;
    logic [LN_AW-1:0] ln_ofs;
    logic [EP_AW-1:0] ep_ofs;
    logic             ln_step, ep_step;

    dma_cp_regs #(.ADDR_W(ADDR_W), .DW(DW), .LN_AW(LN_AW), .EP_AW(EP_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .st_busy(busy), .st_dir(dir), .st_cnt(cnt),
        .start_req(start_req), .req_dir(req_dir), .req_len(req_len),
        .ln_ofs(ln_ofs), .ep_ofs(ep_ofs)
    );

    dma_cp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .req_dir(req_dir),
        .req_len(req_len), .start_go(start_go), .rd_act(rd_act),
        .wr_vld(wr_vld), .busy(busy), .dir(dir), .cnt(cnt)
    );

    // Source pointer steps on reads, destination pointer on writes.
    always_comb begin
        ln_step = (dir == DIR_EP2LN) ? wr_vld : rd_act;
        ep_step = (dir == DIR_EP2LN) ? rd_act : wr_vld;
    end

    dma_cp_ptr #(.AW(LN_AW)) u_ln_ptr (
        .clk(clk), .rst_n(rst_n), .load(start_go), .ofs(ln_ofs),
        .step(ln_step), .ptr(ln_addr)
    );

    dma_cp_ptr #(.AW(EP_AW)) u_ep_ptr (
        .clk(clk), .rst_n(rst_n), .load(start_go), .ofs(ep_ofs),
        .step(ep_step), .ptr(ep_addr)
    );

    assign ln_we    = wr_vld && (dir == DIR_EP2LN);
    assign ep_we    = wr_vld && (dir == DIR_LN2EP);
    assign ln_wdata = ep_rdata;
    assign ep_wdata = ln_rdata;

    p_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ln_we && ep_we));
    p_dir_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ln_we |-> dir == DIR_EP2LN);
endmodule

// File: tb/sim_word_copy_dma.sv
module sim_word_copy_dma;
    localparam int PERIOD = 10;
    localparam int LN_N   = 16384;
    localparam int EP_N   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack;
    logic [13:0] ln_addr;
    logic [31:0] ln_wdata, ln_rdata;
    logic        ln_we;
    logic [9:0]  ep_addr;
    logic [31:0] ep_wdata, ep_rdata;
    logic        ep_we;

    logic [31:0] ln_mem [0:LN_N-1];
    logic [31:0] ep_mem [0:EP_N-1];

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // reference model state
    bit m_valid = 0;
    int m_s = 0, m_len = 0, m_dir = 0;
    int m_ln_ofs = 0, m_ep_ofs = 0;
    int q_edge[$];
    bit q_ln[$];
    int q_addr[$];
    logic [31:0] q_data[$];

    word_copy_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .ln_addr(ln_addr), .ln_wdata(ln_wdata),
        .ln_we(ln_we), .ln_rdata(ln_rdata), .ep_addr(ep_addr),
        .ep_wdata(ep_wdata), .ep_we(ep_we), .ep_rdata(ep_rdata)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        ln_rdata <= ln_mem[ln_addr];
        ep_rdata <= ep_mem[ep_addr];
        if (ln_we) ln_mem[ln_addr] <= ln_wdata;
        if (ep_we) ep_mem[ep_addr] <= ep_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Cycle-accurate write monitor against the queued model writes (R3 R5 R6 R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ln_we || ep_we) begin
                if (q_edge.size() == 0) begin
                    chk(0, "R6", "unexpected write", {30'b0, ln_we, ep_we}, 32'h0);
                end else begin
                    chk(q_edge[0] == cyc, "R5", "write cycle", cyc, q_edge[0]);
                    chk(ln_we == q_ln[0] && ep_we != q_ln[0], "R6", "dest memory",
                        {30'b0, ln_we, ep_we}, {30'b0, q_ln[0], !q_ln[0]});
                    chk((ln_we ? int'(ln_addr) : int'(ep_addr)) == q_addr[0], "R5", "dest addr",
                        ln_we ? 32'(ln_addr) : 32'(ep_addr), q_addr[0]);
                    chk((ln_we ? ln_wdata : ep_wdata) == q_data[0], "R3", "write data",
                        ln_we ? ln_wdata : ep_wdata, q_data[0]);
                    void'(q_edge.pop_front()); void'(q_ln.pop_front());
                    void'(q_addr.pop_front()); void'(q_data.pop_front());
                end
            end else if (q_edge.size() > 0 && q_edge[0] <= cyc) begin
                chk(0, "R3", "missing write", cyc, q_edge[0]);
                void'(q_edge.pop_front()); void'(q_ln.pop_front());
                void'(q_addr.pop_front()); void'(q_data.pop_front());
            end
        end
    end

    function automatic bit busy_at(input int r);
        return m_valid && r > m_s && r <= m_s + m_len + 3;
    endfunction

    function automatic logic [31:0] stat_at(input int r);
        int w;
        logic [12:0] c;
        if (!m_valid) return 32'h0000_1FFF;
        w = r - m_s - 2;
        if (w < 0) w = 0;
        if (w > m_len + 2) w = m_len + 2;
        c = 13'(m_len + 1 - w);
        return {16'h0, busy_at(r), m_dir[0], 1'b0, c};
    endfunction

    task automatic reg_acc(input logic [3:0] a, input bit we, input logic [31:0] d,
                           output logic [31:0] rd, output int edge_idx);
        @(negedge clk);
        reg_valid = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        edge_idx = cyc;
        @(negedge clk);
        chk(reg_ack == 1'b1, "R1", "ack one cycle after access", reg_ack, 1);
        rd = reg_rdata;
        reg_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic set_ofs(input bit ln, input logic [31:0] d);
        logic [31:0] rd; int e;
        reg_acc(ln ? 4'h8 : 4'hC, 1, d, rd, e);
        if (ln) m_ln_ofs = d[13:0]; else m_ep_ofs = d[9:0];
    endtask

    task automatic start(input logic [31:0] d);
        logic [31:0] rd; int e;
        reg_acc(4'h0, 1, d, rd, e);
        if (busy_at(e)) return;   // R7: ignored while busy
        m_valid = 1; m_s = e; m_len = d[11:0]; m_dir = d[14];
        for (int i = 0; i < m_len + 2; i++) begin
            int la, ea;
            la = (m_ln_ofs + i) % LN_N;
            ea = (m_ep_ofs + i) % EP_N;
            q_edge.push_back(e + 2 + i);
            q_ln.push_back(m_dir == 1);
            q_addr.push_back(m_dir == 1 ? la : ea);
            q_data.push_back(m_dir == 1 ? ep_mem[ea] : ln_mem[la]);
        end
    endtask

    task automatic rd_status(input string req, output logic [31:0] v);
        int e;
        reg_acc(4'h0, 0, 32'h0, v, e);
        chk(v == stat_at(e), req, "status word", v, stat_at(e));
    endtask

    task automatic poll_idle(input string req);
        logic [31:0] v;
        for (int k = 0; k < 5000; k++) begin
            rd_status(req, v);
            if (!v[15]) break;
        end
    endtask

    task automatic rd_zero(input logic [3:0] a, input string req);
        logic [31:0] v; int e;
        reg_acc(a, 0, 32'h0, v, e);
        chk(v == 32'h0, req, "read returns zero", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < LN_N; i++) ln_mem[i] = 32'h1000_0000 ^ (i * 32'h9E37_79B1);
        for (int i = 0; i < EP_N; i++) ep_mem[i] = 32'hE000_0000 ^ (i * 32'h85EB_CA6B);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 R2: reset status is idle, all ones
        rd_status("R10", v);
        chk(v == 32'h0000_1FFF, "R10", "reset status", v, 32'h0000_1FFF);
        rd_zero(4'h8, "R9");
        rd_zero(4'hC, "R9");
        // R8: offsets take only their low bits; R9 write-only reads give zero
        set_ofs(1, 32'hFFFF_C005);
        set_ofs(0, 32'hFFFF_FC07);
        rd_zero(4'h8, "R9");
        rd_zero(4'h4, "R9");
        // R3: smallest length, two words, line to endpoint
        start(32'h0000_0000);
        poll_idle("R2");
        // R5: endpoint to line, source wraps at the endpoint top
        set_ofs(1, 32'd100);
        set_ofs(0, 32'd1020);
        start(32'h0000_4005);
        poll_idle("R4");
        // R5 R3: line source wraps at 16383, junk bits ignored
        set_ofs(1, 32'd16382);
        set_ofs(0, 32'd200);
        start(32'hFFFF_B003);
        poll_idle("R3");
        // R7 R8: start and offset writes during a running copy
        set_ofs(1, 32'd300);
        set_ofs(0, 32'd400);
        start(32'h0000_0028);
        set_ofs(1, 32'd900);
        set_ofs(0, 32'd50);
        start(32'h0000_4002);
        rd_status("R7", v);
        chk(v[14] == 1'b0, "R7", "direction unchanged", v[14], 0);
        poll_idle("R7");
        start(32'h0000_4002);
        poll_idle("R8");
        // R4: largest length field, 4097 words
        set_ofs(1, 32'd10);
        set_ofs(0, 32'd3);
        start(32'h0000_0FFF);
        poll_idle("R4");
        rd_status("R4", v);
        chk(v[12:0] == 13'h1FFF && !v[15], "R4", "done reads all ones", v, 32'h1FFF);
        repeat (4) @(negedge clk);
        chk(q_edge.size() == 0, "R3", "all words written", q_edge.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule